// File: doc/BRIEF.md
# Interrupt Pin Delivery and EOI Engine

This block sits behind an interrupt-routing register front-end. It watches a set of interrupt inputs that are driven through per-pin commands: assert, deassert and pulse. When a pin becomes active it builds an interrupt message from that pin's 64-bit routing entry. The routing entries themselves live in the front-end and are presented to this block as one flat bus. The block owns the remote-IRR handshake bit of each pin. It reports that bit back on `irr_out` so the front-end can merge it into what software reads.

Each pin keeps a small signed activity count. Only a move of the count from zero to one counts as a new activation. A masked entry drops the activation. A level-triggered entry delivers once and then waits in remote IRR until an end-of-interrupt (EOI) naming its vector arrives. An EOI starts a scan that visits the pins in ascending order, one per cycle. Each pin whose remote IRR is set and whose vector matches is released, and any such pin that is still active is delivered again. Messages leave through a valid/ready handshake, and the lowest-numbered waiting pin goes first.

Top module: `ipd_engine`

## Requirements
- R1: After reset, no message is offered, every remote-IRR bit is 0, the scan is idle (`busy` = 0), and `cmd_ready` and `eoi_ready` are 1.
- R2: An accepted command on a pin whose count is 0 and that raises the count to 1 offers a message from the clock edge that accepts it. The message fields are: vector = entry[7:0], delivery mode = entry[10:8], logical destination = entry[11] (0 means physical), level flag = entry[15], and `msg_pin` = the pin number.
- R3: `cmd_kind` 0 adds one to the count and 1 subtracts one. Only a move from 0 to 1 attempts delivery. A second assert, or a deassert, offers no message. A pin brought back to 0 delivers again on its next assert.
- R4: `cmd_kind` 2 (pulse) is an add followed by a subtract in the same command. From count 0 it delivers once, and it leaves the count unchanged.
- R5: When entry bit 16 (mask) is set, an activation sends nothing.
- R6: For a level entry (bit 15 = 1), a delivery sets the pin's remote-IRR bit. While that bit is set, further activations of the pin are dropped. Edge entries never set it.
- R7: `msg_dest` is 15 bits wide. Its bits 7:0 come from entry[63:56] and its bits 14:8 come from entry[55:49].
- R8: On an accepted EOI, every pin whose remote-IRR bit is set and whose vector equals `eoi_vector` has that bit cleared. If such a pin's count is still above 0, it is delivered again, which sets the bit once more. Pins with other vectors keep their bit.
- R9: An accepted EOI raises `busy` for exactly NPINS cycles. While `busy` is high, `cmd_ready` and `eoi_ready` are 0 and no command or EOI is taken.
- R10: A waiting message stays offered until `msg_ready` is seen. When several pins wait, the lowest-numbered pin is offered first.
- R11: The count saturates at +31 and at −32 and never wraps. `cnt_err` pulses for one cycle after any command that leaves a count below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_tbl | input | NPINS*64 | Routing entries from the front-end, pin p at bits p*64 +: 64 |
| irr_out | output | NPINS | Remote-IRR bit of each pin |
| cmd_valid | input | 1 | Pin command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_pin | input | PW | Pin addressed by the command |
| cmd_kind | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 no effect |
| eoi_valid | input | 1 | EOI offered |
| eoi_ready | output | 1 | EOI can be taken |
| eoi_vector | input | 8 | Vector named by the EOI |
| busy | output | 1 | EOI scan in progress |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken by the consumer |
| msg_pin | output | PW | Source pin of the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | 1 = logical destination, 0 = physical |
| msg_level | output | 1 | 1 = level triggered |
| msg_dest | output | 15 | Widened destination |
| cnt_err | output | 1 | A count went negative on the last command |

## Verification
A sweep over every pin checks that each field of the routing entry lands in the right message bit. A shifted field or a missing destination extension would show up on some pin. Counter tests aim at double asserts, pulses and both saturation limits. A design that delivered on every assert, wrapped its count, or missed the negative flag would either send extra messages or fail to deliver when the count returns to zero. Level tests check that remote IRR blocks re-delivery and that only an EOI with the matching vector releases it. They also check that a still-active pin is sent again after the EOI and that the scan holds `busy` for exactly one cycle per pin. Priority tests queue two pins and stall the consumer, so that sending the wrong pin first or dropping a message without `msg_ready` is caught.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
    localparam int ENTRY_W = 64;

    typedef enum logic [1:0] {
        CMD_RAISE = 2'd0,
        CMD_LOWER = 2'd1,
        CMD_BLIP  = 2'd2,
        CMD_NOP   = 2'd3
    } pin_cmd_e;

    // bit positions inside a routing entry
    localparam int F_MASK   = 16;
    localparam int F_LEVEL  = 15;
    localparam int F_LOGIC  = 11;
endpackage

// File: rtl/ipd_pin_counter.sv
module ipd_pin_counter #(
    parameter int CW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic rise,
    output logic neg,
    output logic positive
);
    localparam logic signed [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};
    localparam logic signed [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};
    localparam logic signed [CW-1:0] ONE  = 1;

    logic signed [CW-1:0] cnt_q, cnt_d, mid;

    always_comb begin
        mid   = cnt_q;
        cnt_d = cnt_q;
        if (inc) mid = (cnt_q == CMAX) ? cnt_q : cnt_q + ONE;
        cnt_d = mid;
        if (dec) cnt_d = (mid == CMIN) ? mid : mid - ONE;
        rise     = inc && (cnt_q == '0);
        neg      = (inc || dec) && (cnt_d < 0);
        positive = (cnt_q > 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ipd_first_set.sv
module ipd_first_set #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ipd_engine.sv
module ipd_engine
    import ipd_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int CW    = 6,
    localparam int PW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPINS*ENTRY_W-1:0] entry_tbl,
    output logic [NPINS-1:0]         irr_out,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [PW-1:0]            cmd_pin,
    input  logic [1:0]               cmd_kind,
    input  logic                     eoi_valid,
    output logic                     eoi_ready,
    input  logic [7:0]               eoi_vector,
    output logic                     busy,
    output logic                     msg_valid,
    input  logic                     msg_ready,
    output logic [PW-1:0]            msg_pin,
    output logic [7:0]               msg_vector,
    output logic [2:0]               msg_mode,
    output logic                     msg_logical,
    output logic                     msg_level,
    output logic [14:0]              msg_dest,
    output logic                     cnt_err
);
    typedef struct packed {
        logic [NPINS-1:0] irr;
        logic [NPINS-1:0] pend;
        logic             scan;
        logic [PW-1:0]    idx;
        logic [7:0]       vec;
        logic             err;
    } state_t;

    state_t st_q, st_d;

    logic [NPINS-1:0] inc_v, dec_v, rise_v, neg_v, pos_v;
    logic             cmd_acc;
    logic             pick_any;
    logic [PW-1:0]    pick_idx;
    logic [ENTRY_W-1:0] sel_ent;

    assign cmd_ready = !st_q.scan;
    assign eoi_ready = !st_q.scan;
    assign busy      = st_q.scan;
    assign irr_out   = st_q.irr;
    assign cnt_err   = st_q.err;
    assign cmd_acc   = cmd_valid && !st_q.scan;

    always_comb begin
        for (int p = 0; p < NPINS; p++) begin
            inc_v[p] = cmd_acc && (cmd_pin == PW'(p)) &&
                       (cmd_kind == CMD_RAISE || cmd_kind == CMD_BLIP);
            dec_v[p] = cmd_acc && (cmd_pin == PW'(p)) &&
                       (cmd_kind == CMD_LOWER || cmd_kind == CMD_BLIP);
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        ipd_pin_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (inc_v[g]),
            .dec      (dec_v[g]),
            .rise     (rise_v[g]),
            .neg      (neg_v[g]),
            .positive (pos_v[g])
        );
    end

    ipd_first_set #(.N(NPINS)) u_pick (
        .req (st_q.pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign sel_ent     = entry_tbl[pick_idx*ENTRY_W +: ENTRY_W];
    assign msg_valid   = pick_any;
    assign msg_pin     = pick_idx;
    assign msg_vector  = sel_ent[7:0];
    assign msg_mode    = sel_ent[10:8];
    assign msg_logical = sel_ent[F_LOGIC];
    assign msg_level   = sel_ent[F_LEVEL];
    assign msg_dest    = {sel_ent[55:49], sel_ent[63:56]};

    always_comb begin
        logic [ENTRY_W-1:0] ent;
        logic               hit, irr_now, attempt;
        st_d     = st_q;
        st_d.err = |neg_v;
        ent      = '0;

        if (msg_valid && msg_ready) st_d.pend[pick_idx] = 1'b0;

        for (int p = 0; p < NPINS; p++) begin
            ent     = entry_tbl[p*ENTRY_W +: ENTRY_W];
            hit     = st_q.scan && (st_q.idx == PW'(p)) && st_q.irr[p] &&
                      (ent[7:0] == st_q.vec);
            irr_now = st_q.irr[p] && !hit;
            attempt = rise_v[p] || (hit && pos_v[p]);
            st_d.irr[p] = irr_now;
            if (attempt && !ent[F_MASK]) begin
                if (ent[F_LEVEL]) begin
                    if (!irr_now) begin
                        st_d.irr[p]  = 1'b1;
                        st_d.pend[p] = 1'b1;
                    end
                end else begin
                    st_d.pend[p] = 1'b1;
                end
            end
        end

        if (st_q.scan) begin
            if (st_q.idx == PW'(NPINS - 1)) st_d.scan = 1'b0;
            else                            st_d.idx  = st_q.idx + 1'b1;
        end else if (eoi_valid) begin
            st_d.scan = 1'b1;
            st_d.idx  = '0;
            st_d.vec  = eoi_vector;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ipd_engine_chk.sv
module ipd_engine_chk #(
    parameter int NPINS = 32,
    parameter int PW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             eoi_valid,
    input logic             eoi_ready,
    input logic             busy,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [PW-1:0]    msg_pin,
    input logic [NPINS-1:0] irr_out,
    input logic             cnt_err
);
    // R10: an offered message is withdrawn only by a handshake
    assert_msg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid);

    // R10: a stalled message keeps the same or a lower-numbered pin
    assert_pin_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_pin <= $past(msg_pin)));

    // R9: a scan starts only from an accepted EOI
    assert_scan_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(eoi_valid && eoi_ready));

    // R9: nothing is taken while scanning
    assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!cmd_ready && !eoi_ready));

    // R11: the error pulse follows an accepted command
    assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err |-> $past(cmd_valid && cmd_ready));

    // R6: remote IRR bits are set only by a command or a scan step
    assert_irr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr_out & ~$past(irr_out)) != '0) |-> $past((cmd_valid && cmd_ready) || busy));

    // R8: remote IRR bits are cleared only during a scan
    assert_irr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irr_out & $past(irr_out)) != '0) |-> $past(busy));
endmodule

bind ipd_engine ipd_engine_chk #(.NPINS(NPINS), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .eoi_valid (eoi_valid),
    .eoi_ready (eoi_ready),
    .busy      (busy),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_pin   (msg_pin),
    .irr_out   (irr_out),
    .cnt_err   (cnt_err)
);

// File: tb/test_ipd_engine.sv
module test_ipd_engine;
    localparam int NP = 32;
    localparam int PW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [63:0] cfg [NP];
    logic [NP*64-1:0] entry_tbl;
    logic [NP-1:0] irr_out;
    logic cmd_valid = 0, cmd_ready;
    logic [PW-1:0] cmd_pin = '0;
    logic [1:0] cmd_kind = 2'd3;
    logic eoi_valid = 0, eoi_ready;
    logic [7:0] eoi_vector = '0;
    logic busy, msg_valid, msg_ready = 0;
    logic [PW-1:0] msg_pin;
    logic [7:0] msg_vector;
    logic [2:0] msg_mode;
    logic msg_logical, msg_level;
    logic [14:0] msg_dest;
    logic cnt_err;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    always_comb for (int p = 0; p < NP; p++) entry_tbl[p*64 +: 64] = cfg[p];

    ipd_engine i_ipd_engine (
        .clk(clk), .rst_n(rst_n), .entry_tbl(entry_tbl), .irr_out(irr_out),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_pin(cmd_pin),
        .cmd_kind(cmd_kind), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
        .eoi_vector(eoi_vector), .busy(busy), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_pin(msg_pin), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_level(msg_level),
        .msg_dest(msg_dest), .cnt_err(cnt_err)
    );

    function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                       input logic lg, input logic lvl, input logic msk,
                                       input logic [7:0] d8, input logic [6:0] ext);
        return {d8, ext, 32'h0, msk, lvl, 1'b0, 2'b00, lg, mode, vec};
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(input int pin, input int kind);
        cmd_pin = PW'(pin); cmd_kind = 2'(kind); cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0; cmd_kind = 2'd3;
    endtask

    task automatic take();
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
    endtask

    task automatic eoi(input logic [7:0] v, output int cyc);
        eoi_vector = v; eoi_valid = 1;
        @(negedge clk);
        eoi_valid = 0;
        cyc = 0;
        while (busy && cyc < 100) begin
            if (cmd_ready || eoi_ready) check("R9 ready low while busy", 1, 0);
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int p = 0; p < NP; p++) cfg[p] = mk(8'h20 + 8'(p), 3'(p), 1'(p), 0, 0, 8'(p*7+1), 7'(p*3));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 msg_valid", msg_valid, 0);
        check("R1 irr", irr_out, 0);
        check("R1 busy", busy, 0);
        check("R1 ready", {cmd_ready, eoi_ready}, 3);

        // R2, R7: field sweep over every pin
        for (int p = 0; p < NP; p++) begin
            cmd(p, 0);
            check("R2 valid", msg_valid, 1);
            check("R2 pin", msg_pin, p);
            check("R2 vector", msg_vector, 32 + p);
            check("R2 mode", msg_mode, p % 8);
            check("R2 logical", msg_logical, p % 2);
            check("R2 level", msg_level, 0);
            check("R7 dest", msg_dest, ((p*3 % 128) << 8) | ((p*7+1) % 256));
            take();
            check("R10 cleared", msg_valid, 0);
            cmd(p, 1);
        end
        check("R6 edge no irr", irr_out, 0);

        // R3
        cmd(3, 0); take();
        cmd(3, 0);
        check("R3 second assert", msg_valid, 0);
        cmd(3, 1);
        check("R3 deassert", msg_valid, 0);
        cmd(3, 1);
        cmd(3, 0);
        check("R3 back to zero redelivers", msg_valid, 1);
        take(); cmd(3, 1);

        // R4
        cmd(4, 2);
        check("R4 pulse delivers", msg_valid, 1);
        check("R4 pulse pin", msg_pin, 4);
        take();
        cmd(4, 0);
        check("R4 count unchanged", msg_valid, 1);
        take(); cmd(4, 1);

        // R5
        cfg[5][16] = 1;
        cmd(5, 0);
        check("R5 masked", msg_valid, 0);
        cmd(5, 1);
        cfg[5][16] = 0;

        // R6, R8, R9
        cfg[6] = mk(8'h66, 3'd1, 0, 1, 0, 8'h12, 7'h05);
        cmd(6, 0);
        check("R6 level msg", msg_level, 1);
        check("R6 irr set", irr_out, 32'h40);
        take();
        cmd(6, 1); cmd(6, 0);
        check("R6 blocked by irr", msg_valid, 0);
        eoi(8'h65, n);
        check("R9 scan length", n, NP);
        check("R8 other vector keeps irr", irr_out, 32'h40);
        check("R8 no msg", msg_valid, 0);
        eoi(8'h66, n);
        check("R9 scan length", n, NP);
        check("R8 redelivered", msg_valid, 1);
        check("R8 pin", msg_pin, 6);
        check("R8 irr set again", irr_out, 32'h40);
        take();
        cmd(6, 1);
        eoi(8'h66, n);
        check("R8 irr cleared", irr_out, 0);
        check("R8 no redelivery", msg_valid, 0);

        // R10
        cmd(9, 0); cmd(2, 0);
        check("R10 lowest first", msg_pin, 2);
        repeat (3) @(negedge clk);
        check("R10 held", {msg_valid, 3'b0, msg_pin}, {1'b1, 3'b0, 5'd2});
        take();
        check("R10 next", msg_pin, 9);
        take();
        check("R10 drained", msg_valid, 0);
        cmd(9, 1); cmd(2, 1);

        // R11 upper saturation
        cfg[7][16] = 1;
        for (int i = 0; i < 40; i++) cmd(7, 0);
        check("R11 no err high", cnt_err, 0);
        for (int i = 0; i < 31; i++) cmd(7, 1);
        cfg[7][16] = 0;
        cmd(7, 0);
        check("R11 saturate high", msg_valid, 1);
        take(); cmd(7, 1);
        // R11 lower saturation
        cmd(8, 1);
        check("R11 err pulse", cnt_err, 1);
        @(negedge clk);
        check("R11 err one cycle", cnt_err, 0);
        for (int i = 0; i < 39; i++) cmd(8, 1);
        for (int i = 0; i < 32; i++) cmd(8, 0);
        check("R11 no msg while negative", msg_valid, 0);
        cmd(8, 0);
        check("R11 saturate low", msg_valid, 1);
        take();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule